// File: doc/BRIEF.md
# 16-bit ALU with status flags

This block is the combinational arithmetic-logic unit of a 16-bit register-oriented processor. Each evaluation takes a source operand, a destination operand, the current carry flag, a 4-bit operation code and a byte/word select. It returns the result, a write-enable that tells the register path whether to store that result, next values for the negative, zero, carry and overflow flags, and a 4-bit mask naming the flags that the operation updates.

The operations are binary and carry-chained add and subtract, compare, AND, bit test, bit clear, bit set, XOR, an arithmetic right shift, a right rotate through carry, byte swap and sign extension. Subtraction is done as addition of the inverted source, so a carry flag of 1 after a subtract means that no borrow occurred. In byte mode every flag is taken from an 8-bit view of the operands, and the upper result byte is zero. Byte swap and sign extension always work on the whole word.

Top module: `alu16_core`

## Requirements
- R1: Opcode 0 (add) returns dst + src and opcode 1 (add with carry) returns dst + src + carryIn; C is the carry out of the operand MSB, N is the result MSB, Z flags a zero result, and V is set when both operands share a sign that the result lacks; the write-enable is high and flagUpd is 4'b1111.
- R2: Opcode 2 (subtract) returns dst + NOT(src) + 1 and opcode 3 (subtract with carry) returns dst + NOT(src) + carryIn; C is the carry out of the MSB (1 = no borrow), V is set when the operand signs differ and the result sign differs from that of dst; N and Z as in R1, write-enable high, all four flags updated.
- R3: Opcode 4 (compare) produces the flags of opcode 2 and opcode 6 (bit test) the flags of opcode 5, both with the write-enable low and flagUpd 4'b1111.
- R4: Opcode 5 (AND) and opcode 9 (XOR) store src AND dst and src XOR dst; for opcodes 5, 6 and 9, N is the result MSB, Z flags a zero result, C = NOT Z; V is 0 for 5 and 6, and for 9 V is set only when both operands are negative.
- R5: Opcode 7 (bit clear) stores NOT(src) AND dst and opcode 8 (bit set) stores src OR dst, with the write-enable high and flagUpd 4'b0000.
- R6: Opcode 10 (arithmetic right shift) shifts dst right one place keeping its MSB; C takes the old LSB, V is 0, N and Z follow the result; all flags updated.
- R7: Opcode 11 (rotate right through carry) shifts dst right one place with carryIn entering the MSB; C takes the old LSB, V is set when dst is non-negative and carryIn is 1; N and Z follow the result; all flags updated.
- R8: Opcode 12 (byte swap) exchanges bits 15..8 with bits 7..0 and updates no flag; opcode 13 (sign extension) copies bit 7 into bits 15..8, sets N and Z from the 16-bit result, C = NOT Z and V = 0; both write the result and ignore byte mode.
- R9: With byteMode high, every opcode except 12 and 13 takes bit 7 as the MSB and the carry out of bit 7 as C, computes Z over bits 7..0, and drives result bits 15..8 to zero.
- R10: Opcodes 14 and 15 are reserved: result 0, write-enable low, flagUpd 4'b0000.
- R11: flagUpd bit 0 covers C, bit 1 Z, bit 2 N, bit 3 V; a flag output whose mask bit is clear is driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcOp | input | 16 | Source operand |
| dstOp | input | 16 | Destination operand |
| carryIn | input | 1 | Current carry flag |
| opSel | input | 4 | Operation code |
| byteMode | input | 1 | 1 selects 8-bit operation |
| result | output | 16 | Operation result |
| resultWe | output | 1 | Result is to be written back |
| flagN | output | 1 | Next negative flag |
| flagZ | output | 1 | Next zero flag |
| flagC | output | 1 | Next carry flag |
| flagV | output | 1 | Next overflow flag |
| flagUpd | output | 4 | Flag update mask {V,N,Z,C} |

## Verification
The byte-width select and the carry chain meet in the same evaluation: a narrow add or subtract must take its carry and overflow from bit 7 while the upper operand bytes hold values that would carry differently on the full word. The bench provokes this with directed vectors such as 8'hFF plus carry-in with non-zero upper bytes and 8'h7F plus one, then with several thousand random operands, opcodes and byte selects, and judges every evaluation against a behavioural model that masks integer sums to the chosen width.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_N  = 2;
  localparam int FLG_V  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_TEST = 4'd6,
    OP_CLRB = 4'd7,
    OP_SETB = 4'd8,
    OP_XOR  = 4'd9,
    OP_SHRA = 4'd10,
    OP_RORC = 4'd11,
    OP_SWAP = 4'd12,
    OP_SEXT = 4'd13
  } aluOp_e;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_SUM, SEL_AND, SEL_BIC, SEL_BIS,
    SEL_XOR, SEL_SHRA, SEL_RORC, SEL_SWAP, SEL_SEXT
  } resSel_e;

  typedef enum logic [2:0] {
    FR_NONE, FR_ARITH, FR_LOGIC, FR_XOR, FR_SHRA, FR_RORC
  } flagRule_e;

  typedef struct packed {
    resSel_e   resSel;
    flagRule_e flagRule;
    logic      invertSrc;
    logic      useCarry;
    logic      writeEn;
    logic      wholeWord;
  } ctrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrl_t           strobes
);

  always_comb begin
    strobes = '0;
    strobes.resSel   = SEL_ZERO;
    strobes.flagRule = FR_NONE;
    case (opSel)
      OP_ADD, OP_ADDC: begin
        strobes.resSel   = SEL_SUM;
        strobes.flagRule = FR_ARITH;
        strobes.useCarry = (opSel == OP_ADDC);
        strobes.writeEn  = 1'b1;
      end
      OP_SUB, OP_SUBC, OP_CMP: begin
        strobes.resSel    = SEL_SUM;
        strobes.flagRule  = FR_ARITH;
        strobes.invertSrc = 1'b1;
        strobes.useCarry  = (opSel == OP_SUBC);
        strobes.writeEn   = (opSel != OP_CMP);
      end
      OP_AND, OP_TEST: begin
        strobes.resSel   = SEL_AND;
        strobes.flagRule = FR_LOGIC;
        strobes.writeEn  = (opSel == OP_AND);
      end
      OP_CLRB: begin
        strobes.resSel  = SEL_BIC;
        strobes.writeEn = 1'b1;
      end
      OP_SETB: begin
        strobes.resSel  = SEL_BIS;
        strobes.writeEn = 1'b1;
      end
      OP_XOR: begin
        strobes.resSel   = SEL_XOR;
        strobes.flagRule = FR_XOR;
        strobes.writeEn  = 1'b1;
      end
      OP_SHRA: begin
        strobes.resSel   = SEL_SHRA;
        strobes.flagRule = FR_SHRA;
        strobes.writeEn  = 1'b1;
      end
      OP_RORC: begin
        strobes.resSel   = SEL_RORC;
        strobes.flagRule = FR_RORC;
        strobes.writeEn  = 1'b1;
      end
      OP_SWAP: begin
        strobes.resSel    = SEL_SWAP;
        strobes.writeEn   = 1'b1;
        strobes.wholeWord = 1'b1;
      end
      OP_SEXT: begin
        strobes.resSel    = SEL_SEXT;
        strobes.flagRule  = FR_LOGIC;
        strobes.writeEn   = 1'b1;
        strobes.wholeWord = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic              carryIn,
  input  logic              byteMode,
  input  ctrl_t             ctl,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] flagVal,
  output logic [FLAG_W-1:0] flagUpd
);

  localparam int HALF_W = DATA_W / 2;

  logic              narrow;
  logic [DATA_W-1:0] addB;
  logic              addCin;
  logic [DATA_W:0]   sumFull;
  logic [HALF_W:0]   sumLow;
  logic [DATA_W-1:0] rawRes;
  logic              carryOut;
  logic              rMsb, dMsb, sMsb, bMsb, zeroRes;

  assign narrow = byteMode & ~ctl.wholeWord;
  assign addB   = ctl.invertSrc ? ~srcOp : srcOp;
  // subtract without carry-chaining needs the +1 of the two's complement
  assign addCin = ctl.useCarry ? carryIn : ctl.invertSrc;

  assign sumFull = {1'b0, dstOp} + {1'b0, addB} + {{DATA_W{1'b0}}, addCin};
  assign sumLow  = {1'b0, dstOp[HALF_W-1:0]} + {1'b0, addB[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, addCin};

  always_comb begin
    case (ctl.resSel)
      SEL_SUM:  rawRes = sumFull[DATA_W-1:0];
      SEL_AND:  rawRes = srcOp & dstOp;
      SEL_BIC:  rawRes = ~srcOp & dstOp;
      SEL_BIS:  rawRes = srcOp | dstOp;
      SEL_XOR:  rawRes = srcOp ^ dstOp;
      SEL_SHRA: rawRes = narrow
                  ? {{HALF_W{1'b0}}, dstOp[HALF_W-1], dstOp[HALF_W-1:1]}
                  : {dstOp[DATA_W-1], dstOp[DATA_W-1:1]};
      SEL_RORC: rawRes = narrow
                  ? {{HALF_W{1'b0}}, carryIn, dstOp[HALF_W-1:1]}
                  : {carryIn, dstOp[DATA_W-1:1]};
      SEL_SWAP: rawRes = {dstOp[HALF_W-1:0], dstOp[DATA_W-1:HALF_W]};
      SEL_SEXT: rawRes = {{HALF_W{dstOp[HALF_W-1]}}, dstOp[HALF_W-1:0]};
      default:  rawRes = '0;
    endcase
  end

  assign result   = narrow ? {{HALF_W{1'b0}}, rawRes[HALF_W-1:0]} : rawRes;
  assign resultWe = ctl.writeEn;

  assign carryOut = narrow ? sumLow[HALF_W] : sumFull[DATA_W];
  assign rMsb     = narrow ? result[HALF_W-1] : result[DATA_W-1];
  assign dMsb     = narrow ? dstOp[HALF_W-1]  : dstOp[DATA_W-1];
  assign sMsb     = narrow ? srcOp[HALF_W-1]  : srcOp[DATA_W-1];
  assign bMsb     = narrow ? addB[HALF_W-1]   : addB[DATA_W-1];
  assign zeroRes  = (result == '0);

  always_comb begin
    flagVal = '0;
    flagUpd = '1;
    flagVal[FLG_N] = rMsb;
    flagVal[FLG_Z] = zeroRes;
    case (ctl.flagRule)
      FR_ARITH: begin
        flagVal[FLG_C] = carryOut;
        flagVal[FLG_V] = (dMsb == bMsb) && (rMsb != dMsb);
      end
      FR_LOGIC: flagVal[FLG_C] = ~zeroRes;
      FR_XOR: begin
        flagVal[FLG_C] = ~zeroRes;
        flagVal[FLG_V] = sMsb & dMsb;
      end
      FR_SHRA:  flagVal[FLG_C] = dstOp[0];
      FR_RORC: begin
        flagVal[FLG_C] = dstOp[0];
        flagVal[FLG_V] = ~dMsb & carryIn;
      end
      default: begin
        flagVal = '0;
        flagUpd = '0;
      end
    endcase
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
(
  input  logic [15:0] srcOp,
  input  logic [15:0] dstOp,
  input  logic        carryIn,
  input  logic [3:0]  opSel,
  input  logic        byteMode,
  output logic [15:0] result,
  output logic        resultWe,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagC,
  output logic        flagV,
  output logic [3:0]  flagUpd
);

  ctrl_t             strobes;
  logic [FLAG_W-1:0] flagVal;

  alu16_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu16_datapath #(.DATA_W(16)) u_dp (
    .srcOp    (srcOp),
    .dstOp    (dstOp),
    .carryIn  (carryIn),
    .byteMode (byteMode),
    .ctl      (strobes),
    .result   (result),
    .resultWe (resultWe),
    .flagVal  (flagVal),
    .flagUpd  (flagUpd)
  );

  assign flagN = flagVal[FLG_N];
  assign flagZ = flagVal[FLG_Z];
  assign flagC = flagVal[FLG_C];
  assign flagV = flagVal[FLG_V];

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk
  import alu16_pkg::*;
(
  input logic [15:0] srcOp,
  input logic [15:0] dstOp,
  input logic        carryIn,
  input logic [3:0]  opSel,
  input logic        byteMode,
  input logic [15:0] result,
  input logic        resultWe,
  input logic        flagN,
  input logic        flagZ,
  input logic        flagC,
  input logic        flagV,
  input logic [3:0]  flagUpd
);

  logic isLogicC;
  assign isLogicC = (opSel == OP_AND) || (opSel == OP_TEST)
                 || (opSel == OP_XOR) || (opSel == OP_SEXT);

  always_comb begin
    if (opSel == OP_CMP || opSel == OP_TEST)
      a_r3_no_writeback: assert (!resultWe && flagUpd == 4'hF)
        else $error("compare/test wrote result");
    if (opSel == OP_CLRB || opSel == OP_SETB)
      a_r5_flags_kept: assert (flagUpd == 4'h0 && resultWe)
        else $error("bit set/clear touched flags");
    if (isLogicC)
      a_r4_carry_not_zero: assert (flagC == !flagZ)
        else $error("logic carry is not inverse of zero");
    if (opSel == OP_SEXT)
      a_r8_sext_upper: assert (result[15:8] == {8{dstOp[7]}} && result[7:0] == dstOp[7:0])
        else $error("sign extension upper byte wrong");
    if (opSel == OP_RORC)
      a_r7_rotate_carry: assert (flagC == dstOp[0] && (byteMode ? result[7] : result[15]) == carryIn)
        else $error("rotate through carry wrong");
    if (byteMode && opSel != OP_SWAP && opSel != OP_SEXT)
      a_r9_upper_zero: assert (result[15:8] == 8'h00)
        else $error("byte mode upper byte not zero");
    if (opSel >= 4'd14)
      a_r10_reserved_idle: assert (!resultWe && flagUpd == 4'h0 && result == 16'h0)
        else $error("reserved opcode active");
    a_r11_masked_zero: assert ((flagUpd[0] || !flagC) && (flagUpd[1] || !flagZ)
                            && (flagUpd[2] || !flagN) && (flagUpd[3] || !flagV))
      else $error("masked flag not zero");
    if (flagUpd[1] && !byteMode && srcOp == srcOp)
      a_r1_zero_consistent: assert (flagZ == (result == 16'h0) || opSel == OP_CMP || opSel == OP_TEST)
        else $error("zero flag disagrees with result");
  end

endmodule

bind alu16_core alu16_core_chk u_chk (
  .srcOp    (srcOp),
  .dstOp    (dstOp),
  .carryIn  (carryIn),
  .opSel    (opSel),
  .byteMode (byteMode),
  .result   (result),
  .resultWe (resultWe),
  .flagN    (flagN),
  .flagZ    (flagZ),
  .flagC    (flagC),
  .flagV    (flagV),
  .flagUpd  (flagUpd)
);

// File: tb/alu16_core_tb.sv
`timescale 1ns/1ps
module alu16_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] srcOp = '0, dstOp = '0;
  logic        carryIn = 1'b0, byteMode = 1'b0;
  logic [3:0]  opSel = '0;
  logic [15:0] result;
  logic        resultWe, flagN, flagZ, flagC, flagV;
  logic [3:0]  flagUpd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  alu16_core u_dut (
    .srcOp(srcOp), .dstOp(dstOp), .carryIn(carryIn), .opSel(opSel),
    .byteMode(byteMode), .result(result), .resultWe(resultWe),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .flagUpd(flagUpd)
  );

  // behavioural reference: integer arithmetic masked to the operating width
  task automatic refModel(input logic [15:0] s, input logic [15:0] d, input logic c,
                          input logic [3:0] op, input logic bm,
                          output logic [15:0] r, output logic we, output logic [3:0] upd,
                          output logic fn, output logic fz, output logic fc, output logic fv);
    int unsigned w, m, top, a, b, sum, res;
    bit narrow, setNZ;
    narrow = bm && op != 4'd12 && op != 4'd13;
    w = narrow ? 8 : 16;
    m = (32'd1 << w) - 1;
    top = 32'd1 << (w - 1);
    a = d & m;
    b = s & m;
    res = 0; we = 0; upd = 4'h0; fn = 0; fz = 0; fc = 0; fv = 0; setNZ = 0;
    case (op)
      4'd0, 4'd1: begin
        sum = a + b + ((op == 4'd1) ? c : 0);
        res = sum & m; we = 1; setNZ = 1;
        fc = ((sum >> w) & 1) != 0;
        fv = ((a ^ res) & (b ^ res) & top) != 0;
      end
      4'd2, 4'd3, 4'd4: begin
        sum = a + ((~b) & m) + ((op == 4'd3) ? c : 1);
        res = sum & m; we = (op != 4'd4); setNZ = 1;
        fc = sum > m;
        fv = ((a ^ b) & (a ^ res) & top) != 0;
      end
      4'd5, 4'd6: begin res = a & b; we = (op == 4'd5); setNZ = 1; fc = res != 0; end
      4'd7: begin res = a & (~b) & m; we = 1; end
      4'd8: begin res = a | b; we = 1; end
      4'd9: begin res = a ^ b; we = 1; setNZ = 1; fc = res != 0; fv = (a & b & top) != 0; end
      4'd10: begin res = (a >> 1) | (a & top); we = 1; setNZ = 1; fc = a[0]; end
      4'd11: begin
        res = (a >> 1) | (c ? top : 0); we = 1; setNZ = 1;
        fc = a[0]; fv = ((a & top) == 0) && c;
      end
      4'd12: begin res = {16'h0, d[7:0], d[15:8]}; we = 1; end
      4'd13: begin
        res = d[7] ? ((d & 32'hFF) | 32'hFF00) : (d & 32'hFF);
        we = 1; setNZ = 1; fc = res != 0;
      end
      default: ;
    endcase
    if (setNZ) begin
      upd = 4'hF;
      fn = (res & top) != 0;
      fz = res == 0;
    end
    r = res[15:0];
  endtask

  function automatic string reqTag(input logic [3:0] op, input logic bm);
    string t;
    case (op)
      4'd0, 4'd1: t = "R1";
      4'd2, 4'd3: t = "R2";
      4'd4, 4'd6: t = "R3";
      4'd5, 4'd9: t = "R4";
      4'd7, 4'd8: t = "R5";
      4'd10: t = "R6";
      4'd11: t = "R7";
      4'd12, 4'd13: t = "R8";
      default: t = "R10";
    endcase
    if (bm && op != 4'd12 && op != 4'd13) t = {t, "/R9"};
    return {t, "/R11"};
  endfunction

  task automatic checkNow();
    logic [15:0] eR; logic eWe, eN, eZ, eC, eV; logic [3:0] eUpd;
    refModel(srcOp, dstOp, carryIn, opSel, byteMode, eR, eWe, eUpd, eN, eZ, eC, eV);
    total++;
    if (result !== eR || resultWe !== eWe || flagUpd !== eUpd ||
        flagN !== eN || flagZ !== eZ || flagC !== eC || flagV !== eV) begin
      bad++;
      $display("FAIL %s op=%0d byte=%0b src=%h dst=%h c=%0b: got r=%h we=%0b upd=%b NZCV=%0b%0b%0b%0b exp r=%h we=%0b upd=%b NZCV=%0b%0b%0b%0b",
               reqTag(opSel, byteMode), opSel, byteMode, srcOp, dstOp, carryIn,
               result, resultWe, flagUpd, flagN, flagZ, flagC, flagV,
               eR, eWe, eUpd, eN, eZ, eC, eV);
    end
  endtask

  // drive after the falling edge, compare shortly after the next rising edge
  task automatic applyVec(input logic [3:0] op, input logic [15:0] s, input logic [15:0] d,
                          input logic c, input logic bm);
    @(negedge clk);
    opSel = op; srcOp = s; dstOp = d; carryIn = c; byteMode = bm;
    @(posedge clk);
    #1;
    checkNow();
  endtask

  initial begin
    // R1 reset state: all-zero inputs select add of zeros
    @(posedge clk); #1;
    checkNow();
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    applyVec(4'd0, 16'h0001, 16'hFFFF, 0, 0);  // R1 carry out, zero
    applyVec(4'd0, 16'h0001, 16'h7FFF, 0, 0);  // R1 overflow
    applyVec(4'd1, 16'h0000, 16'hFFFF, 1, 0);  // R1 carry in wraps
    applyVec(4'd2, 16'h0005, 16'h0003, 0, 0);  // R2 borrow, C=0
    applyVec(4'd2, 16'h0001, 16'h8000, 0, 0);  // R2 overflow
    applyVec(4'd3, 16'h0003, 16'h0003, 0, 0);  // R2 carry-in 0 gives -1
    applyVec(4'd4, 16'h1234, 16'h1234, 0, 0);  // R3 equal compare
    applyVec(4'd6, 16'h0200, 16'h0100, 1, 0);  // R3 test zero
    applyVec(4'd9, 16'h8001, 16'h8000, 0, 0);  // R4 xor both negative
    applyVec(4'd5, 16'hAA55, 16'h55AA, 0, 0);  // R4 and zero
    applyVec(4'd7, 16'hFC00, 16'hFFFF, 1, 0);  // R5 clear bits
    applyVec(4'd8, 16'h003F, 16'h0000, 0, 0);  // R5 set bits
    applyVec(4'd10, 16'h0, 16'h8001, 0, 0);    // R6 keeps sign
    applyVec(4'd11, 16'h0, 16'h0002, 1, 0);    // R7 positive with carry: V
    applyVec(4'd11, 16'h0, 16'h8001, 0, 0);    // R7 lsb into carry
    applyVec(4'd12, 16'h0, 16'h12AB, 0, 1);    // R8 swap ignores byte mode
    applyVec(4'd13, 16'h0, 16'h3480, 0, 1);    // R8 sign extend negative
    applyVec(4'd13, 16'h0, 16'hFF00, 0, 0);    // R8 sign extend to zero
    applyVec(4'd1, 16'h1200, 16'h34FF, 1, 1);  // R9 byte carry at bit 7
    applyVec(4'd0, 16'hFF01, 16'hFF7F, 0, 1);  // R9 byte overflow
    applyVec(4'd2, 16'h0001, 16'hAB00, 0, 1);  // R9 byte borrow
    applyVec(4'd11, 16'h0, 16'hFF01, 1, 1);    // R9 byte rotate
    applyVec(4'd14, 16'hFFFF, 16'hFFFF, 1, 0); // R10 reserved
    applyVec(4'd15, 16'h1234, 16'h5678, 0, 1); // R10 reserved

    for (int i = 0; i < 4000; i++)
      applyVec(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
               1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule